// File: doc/BRIEF.md
# SIMT Reconvergence Mask Stack

This block follows branch divergence for one group of lanes that share a single program counter. It keeps a small stack of entries. Each entry holds a next PC, a lane mask and a join PC. The top entry decides which PC is fetched next and which lanes are active. When a branch resolves, the block receives the per-lane taken mask, the taken target, the fall-through PC and the join PC that the compiler computed.

If the active lanes disagree, the current top entry is redirected to the join PC, and one entry is pushed for each path. The taken path is pushed last, so it runs first. A path entry leaves the stack by itself when its PC reaches its join PC. Execution then continues from the entry below it. When every path has reached the join, the lanes that were split run together again.

For straight-line code, the surrounding pipeline reports the PC that execution has reached through the advance input. The stack depth and the lane count are parameters. A divergence that would not fit is dropped, and a sticky flag records that this happened.

Top module: `rstk_reconv_stack`

## Requirements
- R1: After reset, fetch_pc equals START_PC, active_mask is all ones and overflow is 0. The stack then holds only the bottom entry, and the bottom entry has no join PC.
- R2: An advance event (adv_valid with br_valid low) sets fetch_pc to adv_pc one cycle later and leaves active_mask unchanged, as long as adv_pc is not the join PC of the top entry.
- R3: Bit i of a mask stands for lane i (bit 0 is the LSB). Only taken bits of active lanes count. If all active lanes go the same way, nothing is pushed, active_mask stays the same, and fetch_pc becomes br_target if any active lane took the branch, otherwise br_fallthru.
- R4: If the active lanes split, the top entry's next PC becomes br_join. An entry for the not-taken lanes (PC br_fallthru) is pushed, then an entry for the taken lanes (PC br_target). Both carry br_join as their join PC. One cycle later the outputs show br_target with mask taken&active. Example: active 4'b1111 with taken 4'b1001 runs 4'b1001 first and 4'b0110 second.
- R5: When the top entry's next PC becomes equal to its join PC, whether by an advance or by a uniform branch, that entry is popped. One cycle later the outputs show the next PC and the mask of the entry below.
- R6: After both paths of a divergence reach the join, fetch_pc is the join PC and active_mask is the mask from before the branch.
- R7: A path whose start PC already equals br_join is not pushed. Its lanes wait at the join. For example, a branch with br_target equal to br_join pushes only the not-taken entry.
- R8: The bottom entry is never popped. An advance at the bottom sets fetch_pc to any value, including 0, and the mask stays all ones.
- R9: A divergence that needs more entries than are free is dropped as a whole: fetch_pc and active_mask do not change. The overflow output goes to 1 and stays at 1 until reset.
- R10: If br_valid and adv_valid are high in the same cycle, only the branch takes effect and adv_pc is ignored.
- R11: Divergence nests. A branch taken inside a path splits only that path's mask, and the stack unwinds through each join in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch resolves this cycle |
| br_taken | input | LANES | Per-lane taken bits |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Fall-through PC |
| br_join | input | PC_W | Join (reconvergence) PC of the branch |
| adv_valid | input | 1 | Execution reached adv_pc |
| adv_pc | input | PC_W | PC that execution reached |
| fetch_pc | output | PC_W | Registered PC to fetch |
| active_mask | output | LANES | Registered active lane mask |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
Branches are driven with all lanes taken, with no lanes taken, and with taken bits set only on inactive lanes. These cases separate true divergence from a branch that only looks split. Split masks such as 1001/0110 and 1110/0001 check both push order and the per-path masks. A branch whose target equals its join shows that only one entry is pushed. A two-level nest followed by an extra split checks that entries unwind in order and that an overflowing event is dropped as a whole. A uniform branch that lands on the join PC checks that a pop can be triggered by a branch as well as by an advance.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
   // Action chosen for the stack in one cycle
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_UPDATE = 2'd1,
      ACT_PUSH   = 2'd2,
      ACT_POP    = 2'd3
   } act_e;
endpackage

// File: rtl/rstk_split.sv
module rstk_split #(
   parameter int LANES = 4,
   parameter int PC_W  = 16
) (
   input  logic [LANES-1:0] taken,
   input  logic [LANES-1:0] cur_mask,
   input  logic [PC_W-1:0]  tgt,
   input  logic [PC_W-1:0]  fall,
   input  logic [PC_W-1:0]  jn_pc,
   output logic [LANES-1:0] t_mask,
   output logic [LANES-1:0] n_mask,
   output logic             divergent,
   output logic             push_t,
   output logic             push_n,
   output logic [PC_W-1:0]  uni_pc,
   output logic [1:0]       n_push
);
   always_comb begin
      t_mask    = taken & cur_mask;
      n_mask    = ~taken & cur_mask;
      divergent = (|t_mask) && (|n_mask);
      // a path that already starts at the join needs no entry
      push_t    = divergent && (tgt != jn_pc);
      push_n    = divergent && (fall != jn_pc);
      uni_pc    = (|t_mask) ? tgt : fall;
      n_push    = {1'b0, push_t} + {1'b0, push_n};
   end
endmodule

// File: rtl/rstk_regs.sv
module rstk_regs #(
   parameter int              LANES    = 4,
   parameter int              PC_W     = 16,
   parameter int              DEPTH    = 8,
   parameter int              PTR_W    = 3,
   parameter logic [PC_W-1:0] START_PC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic             psh0_en,
   input  logic [PC_W-1:0]  psh0_pc,
   input  logic [LANES-1:0] psh0_mask,
   input  logic             psh1_en,
   input  logic [PC_W-1:0]  psh1_pc,
   input  logic [LANES-1:0] psh1_mask,
   input  logic [PC_W-1:0]  psh_rpc,
   input  logic [PTR_W-1:0] ptr_nxt,
   output logic [PTR_W-1:0] ptr,
   output logic [PC_W-1:0]  top_pc,
   output logic [LANES-1:0] top_mask,
   output logic [PC_W-1:0]  top_rpc,
   output logic [PC_W-1:0]  blw_pc,
   output logic [LANES-1:0] blw_mask
);
   logic [PC_W-1:0]  pc_a   [DEPTH];
   logic [LANES-1:0] mask_a [DEPTH];
   logic [PC_W-1:0]  rpc_a  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [PC_W-1:0]  pc_r;
      logic [LANES-1:0] mask_r;
      logic [PC_W-1:0]  rpc_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pc_r   <= (e == 0) ? START_PC : '0;
            mask_r <= (e == 0) ? '1 : '0;
            rpc_r  <= '0;
         end else if (psh0_en && (int'(ptr) + 1 == e)) begin
            pc_r   <= psh0_pc;
            mask_r <= psh0_mask;
            rpc_r  <= psh_rpc;
         end else if (psh1_en && (int'(ptr) + 2 == e)) begin
            pc_r   <= psh1_pc;
            mask_r <= psh1_mask;
            rpc_r  <= psh_rpc;
         end else if (upd_en && (int'(ptr) == e)) begin
            pc_r   <= upd_pc;
         end
      end
      assign pc_a[e]   = pc_r;
      assign mask_a[e] = mask_r;
      assign rpc_a[e]  = rpc_r;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_nxt;
   end

   always_comb begin
      top_pc   = pc_a[0];
      top_mask = mask_a[0];
      top_rpc  = rpc_a[0];
      blw_pc   = pc_a[0];
      blw_mask = mask_a[0];
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(ptr) == i) begin
            top_pc   = pc_a[i];
            top_mask = mask_a[i];
            top_rpc  = rpc_a[i];
         end
         if (int'(ptr) == i + 1) begin
            blw_pc   = pc_a[i];
            blw_mask = mask_a[i];
         end
      end
   end
endmodule

// File: rtl/rstk_reconv_stack.sv
module rstk_reconv_stack
   import rstk_pkg::*;
#(
   parameter int              LANES    = 4,
   parameter int              PC_W     = 16,
   parameter int              DEPTH    = 8,
   parameter logic [PC_W-1:0] START_PC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             br_valid,
   input  logic [LANES-1:0] br_taken,
   input  logic [PC_W-1:0]  br_target,
   input  logic [PC_W-1:0]  br_fallthru,
   input  logic [PC_W-1:0]  br_join,
   input  logic             adv_valid,
   input  logic [PC_W-1:0]  adv_pc,
   output logic [PC_W-1:0]  fetch_pc,
   output logic [LANES-1:0] active_mask,
   output logic             overflow
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LAST  = DEPTH - 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("rstk_reconv_stack: LANES must be at least 1");
   end
   if (DEPTH < 3) begin : g_bad_depth
      $error("rstk_reconv_stack: DEPTH must be at least 3");
   end
   if (PC_W < 2) begin : g_bad_pcw
      $error("rstk_reconv_stack: PC_W must be at least 2");
   end

   logic [PTR_W-1:0] ptr, ptr_nxt;
   logic [PC_W-1:0]  top_pc, top_rpc, blw_pc, upd_pc;
   logic [LANES-1:0] top_mask, blw_mask;
   logic [LANES-1:0] t_mask, n_mask;
   logic             divergent, push_t, push_n, ovf_set;
   logic [PC_W-1:0]  uni_pc;
   logic [1:0]       n_push;
   act_e             act;
   logic [PC_W-1:0]  pc_d;
   logic [LANES-1:0] mask_d;

   rstk_split #(.LANES(LANES), .PC_W(PC_W)) u_split (
      .taken(br_taken), .cur_mask(top_mask), .tgt(br_target),
      .fall(br_fallthru), .jn_pc(br_join), .t_mask(t_mask),
      .n_mask(n_mask), .divergent(divergent), .push_t(push_t),
      .push_n(push_n), .uni_pc(uni_pc), .n_push(n_push)
   );

   // choose the stack action for this cycle
   always_comb begin
      act     = ACT_HOLD;
      upd_pc  = top_pc;
      ovf_set = 1'b0;
      if (br_valid) begin
         if (divergent) begin
            if (int'(ptr) + int'(n_push) > LAST) begin
               ovf_set = 1'b1;
            end else begin
               upd_pc = br_join;
               act    = (n_push == 2'd0) ? ACT_UPDATE : ACT_PUSH;
            end
         end else begin
            act    = ACT_UPDATE;
            upd_pc = uni_pc;
         end
      end else if (adv_valid) begin
         act    = ACT_UPDATE;
         upd_pc = adv_pc;
      end
      if (act == ACT_UPDATE && ptr != '0 && upd_pc == top_rpc) act = ACT_POP;
   end

   always_comb begin
      unique case (act)
         ACT_PUSH: ptr_nxt = ptr + PTR_W'(n_push);
         ACT_POP:  ptr_nxt = ptr - 1'b1;
         default:  ptr_nxt = ptr;
      endcase
   end

   rstk_regs #(
      .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .START_PC(START_PC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .upd_en(act != ACT_HOLD), .upd_pc(upd_pc),
      .psh0_en(act == ACT_PUSH),
      .psh0_pc(push_n ? br_fallthru : br_target),
      .psh0_mask(push_n ? n_mask : t_mask),
      .psh1_en(act == ACT_PUSH && n_push == 2'd2),
      .psh1_pc(br_target), .psh1_mask(t_mask),
      .psh_rpc(br_join), .ptr_nxt(ptr_nxt), .ptr(ptr),
      .top_pc(top_pc), .top_mask(top_mask), .top_rpc(top_rpc),
      .blw_pc(blw_pc), .blw_mask(blw_mask)
   );

   // next value of the registered top-of-stack view
   always_comb begin
      pc_d   = fetch_pc;
      mask_d = active_mask;
      unique case (act)
         ACT_PUSH: begin
            pc_d   = push_t ? br_target : br_fallthru;
            mask_d = push_t ? t_mask : n_mask;
         end
         ACT_POP: begin
            pc_d   = blw_pc;
            mask_d = blw_mask;
         end
         ACT_UPDATE: begin
            pc_d   = upd_pc;
            mask_d = top_mask;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_pc    <= START_PC;
         active_mask <= '1;
         overflow    <= 1'b0;
      end else begin
         fetch_pc    <= pc_d;
         active_mask <= mask_d;
         overflow    <= overflow | ovf_set;
      end
   end
endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
   parameter int LANES = 4,
   parameter int PC_W  = 16,
   parameter int DEPTH = 8,
   parameter int PTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             br_valid,
   input logic [LANES-1:0] br_taken,
   input logic [PC_W-1:0]  br_target,
   input logic [PC_W-1:0]  br_fallthru,
   input logic [PC_W-1:0]  br_join,
   input logic             adv_valid,
   input logic [PC_W-1:0]  adv_pc,
   input logic [PC_W-1:0]  fetch_pc,
   input logic [LANES-1:0] active_mask,
   input logic             overflow,
   input logic [PTR_W-1:0] ptr,
   input logic [PC_W-1:0]  top_rpc
);
   logic [LANES-1:0] tk, nt;
   assign tk = br_taken & active_mask;
   assign nt = ~br_taken & active_mask;

   AST_BOTTOM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == '0) |-> (active_mask == '1)); // R6

   AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active_mask != '0); // R4

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R9

   AST_ADV_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && adv_valid && ptr == '0) |=>
      (fetch_pc == $past(adv_pc) && active_mask == '1)); // R8

   AST_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && (tk == '0 || nt == '0) && ptr == '0) |=>
      (active_mask == $past(active_mask) && ptr == '0)); // R3

   AST_DIVERGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && tk != '0 && nt != '0 && br_target != br_join &&
       int'(ptr) + 2 <= DEPTH - 1) |=>
      (fetch_pc == $past(br_target) && active_mask == $past(tk))); // R4

   AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && tk != '0 && nt != '0 && br_target != br_join &&
       int'(ptr) == DEPTH - 1) |=>
      ($stable(fetch_pc) && $stable(active_mask) && overflow)); // R9

   AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && adv_valid && ptr != '0 && adv_pc == top_rpc) |=>
      (ptr == $past(ptr) - 1'b1)); // R5
endmodule

bind rstk_reconv_stack rstk_chk #(
   .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
   .br_target(br_target), .br_fallthru(br_fallthru), .br_join(br_join),
   .adv_valid(adv_valid), .adv_pc(adv_pc), .fetch_pc(fetch_pc),
   .active_mask(active_mask), .overflow(overflow), .ptr(ptr), .top_rpc(top_rpc)
);

// File: tb/sim_rstk_reconv_stack.sv
`timescale 1ns/100ps
module sim_rstk_reconv_stack;
   localparam int LANES = 4;
   localparam int PC_W  = 16;
   localparam int DEPTH = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             br_valid = 1'b0;
   logic [LANES-1:0] br_taken = '0;
   logic [PC_W-1:0]  br_target = '0, br_fallthru = '0, br_join = '0;
   logic             adv_valid = 1'b0;
   logic [PC_W-1:0]  adv_pc = '0;
   logic [PC_W-1:0]  fetch_pc;
   logic [LANES-1:0] active_mask;
   logic             overflow;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rstk_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC('0)) u0 (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
      .br_target(br_target), .br_fallthru(br_fallthru), .br_join(br_join),
      .adv_valid(adv_valid), .adv_pc(adv_pc), .fetch_pc(fetch_pc),
      .active_mask(active_mask), .overflow(overflow)
   );

   task automatic see(string req, logic [PC_W-1:0] pc_e, logic [LANES-1:0] m_e);
      n_chk++;
      if (fetch_pc !== pc_e || active_mask !== m_e) begin
         n_bad++;
         $display("FAIL %s: pc=%h mask=%b, expected pc=%h mask=%b",
                  req, fetch_pc, active_mask, pc_e, m_e);
      end
   endtask

   task automatic see_ovf(string req, logic e);
      n_chk++;
      if (overflow !== e) begin
         n_bad++;
         $display("FAIL %s: overflow=%b, expected %b", req, overflow, e);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic branch(logic [LANES-1:0] tk, logic [PC_W-1:0] tg,
                         logic [PC_W-1:0] ft, logic [PC_W-1:0] jn);
      @(negedge clk);
      br_valid = 1'b1; br_taken = tk; br_target = tg; br_fallthru = ft; br_join = jn;
      @(negedge clk);
      br_valid = 1'b0;
   endtask

   task automatic advance(logic [PC_W-1:0] pc);
      @(negedge clk);
      adv_valid = 1'b1; adv_pc = pc;
      @(negedge clk);
      adv_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      see("R1 reset", 16'h0000, 4'b1111);
      see_ovf("R1 reset", 1'b0);
   endtask

   task automatic t_advance();
      advance(16'h0004); see("R2 advance", 16'h0004, 4'b1111);
      advance(16'h0000); see("R8 bottom no pop at pc 0", 16'h0000, 4'b1111);
      advance(16'h0010); see("R8 bottom advance", 16'h0010, 4'b1111);
   endtask

   task automatic t_uniform();
      branch(4'b1111, 16'h0040, 16'h0014, 16'h0080); see("R3 all taken", 16'h0040, 4'b1111);
      branch(4'b0000, 16'h0099, 16'h0044, 16'h0080); see("R3 none taken", 16'h0044, 4'b1111);
   endtask

   task automatic t_diverge();
      branch(4'b1001, 16'h0050, 16'h0060, 16'h0070); see("R4 taken path first", 16'h0050, 4'b1001);
      advance(16'h0054); see("R2 advance in path", 16'h0054, 4'b1001);
      advance(16'h0070); see("R5 pop to other path", 16'h0060, 4'b0110);
      advance(16'h0070); see("R6 rejoin", 16'h0070, 4'b1111);
   endtask

   task automatic t_nested();
      branch(4'b1110, 16'h0100, 16'h0200, 16'h0300); see("R11 outer split", 16'h0100, 4'b1110);
      branch(4'b0110, 16'h0110, 16'h0120, 16'h0130); see("R11 inner split", 16'h0110, 4'b0110);
      branch(4'b0010, 16'h0140, 16'h0150, 16'h0160); see("R9 dropped when full", 16'h0110, 4'b0110);
      see_ovf("R9 overflow set", 1'b1);
      advance(16'h0130); see("R11 inner other path", 16'h0120, 4'b1000);
      advance(16'h0130); see("R11 inner join", 16'h0130, 4'b1110);
      advance(16'h0300); see("R11 outer other path", 16'h0200, 4'b0001);
      advance(16'h0300); see("R6 outer join", 16'h0300, 4'b1111);
      see_ovf("R9 overflow sticky", 1'b1);
   endtask

   task automatic t_if_no_else();
      branch(4'b0101, 16'h0380, 16'h0304, 16'h0380); see("R7 only not-taken pushed", 16'h0304, 4'b1010);
      advance(16'h0380); see("R7 join after single path", 16'h0380, 4'b1111);
   endtask

   task automatic t_branch_pop();
      branch(4'b0011, 16'h0400, 16'h0410, 16'h0420); see("R4 split 0011", 16'h0400, 4'b0011);
      branch(4'b1100, 16'h07AA, 16'h0404, 16'h0500); see("R3 inactive bits ignored", 16'h0404, 4'b0011);
      branch(4'b1111, 16'h0420, 16'h0999, 16'h0500); see("R5 pop by branch", 16'h0410, 4'b1100);
      advance(16'h0420); see("R6 rejoin after branch pop", 16'h0420, 4'b1111);
   endtask

   task automatic t_both();
      @(negedge clk);
      br_valid = 1'b1; br_taken = 4'b1111; br_target = 16'h0500;
      br_fallthru = 16'h0504; br_join = 16'h0600;
      adv_valid = 1'b1; adv_pc = 16'h0600;
      @(negedge clk);
      br_valid = 1'b0; adv_valid = 1'b0;
      see("R10 branch wins over advance", 16'h0500, 4'b1111);
   endtask

   task automatic t_reset_clears();
      do_reset();
      see("R1 second reset", 16'h0000, 4'b1111);
      see_ovf("R9 overflow cleared by reset", 1'b0);
   endtask

   initial begin
      t_reset();
      t_advance();
      t_uniform();
      t_diverge();
      t_nested();
      t_if_no_else();
      t_branch_pop();
      t_both();
      t_reset_clears();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule